// File: doc/BRIEF.md
# AC97 Codec Register Access Port

This block gives a host a single 32-bit register for reaching the 16-bit registers of two attached AC97 codecs. The host writes a codec register index with a direction bit, and the block runs one transaction to the chosen codec. For a read, the result lands in the register's data field. For a write, the data field is sent to the codec. Every completed aligned transaction is also copied into an internal shadow copy of that codec's registers, and the shadow copy can be read through a separate lookup port.

The host register has four byte lanes. Bits 15:0 are the data field. Bits 23:16 are the index byte: bit 23 set means read, and bits 22:16 are the codec register index. Bits 31:24 are the status byte. Bit 31 is a plain stored bit. Bit 30 selects the codec, where 0 is the primary and 1 is the secondary. Bit 27 is the secondary valid flag, bit 25 is the primary valid flag, and bit 24 is busy. Bits 29, 28 and 26 always read 0.

The codec side is a request/commit pair. The request is held for a fixed, parameterised number of cycles, and the commit strobe marks the last cycle. On a read the codec supplies its data in that last cycle, and on a write it takes the data in that cycle.

Top module: `codec_reg_port`

## Requirements
- R1: After reset the host word reads 0x00000000, no request is raised, and every shadow entry reads 0x0000.
- R2: A host write with byte lane 2 enabled, while not busy, with bit 23 clear, an even index and the selected codec present, starts a write. The write goes to codec bit 30, at index bits 22:16, carrying the data field. On completion the shadow entry for that codec and index takes the written data.
- R3: The same start with bit 23 set runs a read. On completion the data field and the shadow entry take the codec's read data. The valid flag is set: bit 25 for the primary codec, bit 27 for the secondary.
- R4: A read request with an odd index makes no codec access. On the next cycle the data field reads 0x0000 and the selected codec's valid flag is set.
- R5: A write request with an odd index makes no codec access. It leaves the data field, the valid flags and the shadow copy unchanged.
- R6: A host write to byte lane 3 takes bits 31 and 30 from the written value. Bits 29:24 keep their current values.
- R7: A request to a codec whose present input is low makes no access, leaves the data field and the valid flags unchanged, and never sets busy.
- R8: While busy is 1, host writes to byte lanes 0, 1 and 2 are ignored.
- R9: Busy (bit 24) and the request stay high for exactly LATENCY cycles after the starting write. The data field does not change before completion.
- R10: A single host write may carry data, index and status lanes together. The new data and the new codec select take effect for the transaction that write starts.
- R11: The valid flags stay set until reset. Writes to the status byte do not clear them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_be | input | 4 | Byte lane enables for the host write |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Current register word |
| cdc_present | input | 2 | Codec present, one bit per codec |
| cdc_req | output | 1 | Transaction in flight |
| cdc_commit | output | 1 | Last cycle of the transaction |
| cdc_write | output | 1 | Transaction is a write |
| cdc_sel | output | 1 | Target codec |
| cdc_index | output | 7 | Codec register index |
| cdc_wdata | output | 16 | Data for a write |
| cdc_rdata | input | 16 | Codec read data, sampled on commit |
| shd_sel | input | 1 | Shadow lookup codec |
| shd_index | input | 7 | Shadow lookup index (bit 0 ignored) |
| shd_data | output | 16 | Shadow lookup result |

## Verification
When an aligned request is accepted at a clock edge, busy is visible from that edge. Busy must still be 1 after LATENCY-1 further edges and must be 0 after exactly LATENCY edges, with the read data and the flag appearing at that same point. Odd-index reads must show 0x0000 and the flag one edge after the write. Ignored and absent-codec requests are checked on the next sample and again a few cycles later. The bench samples on falling edges and counts edges from the accepting edge. A scoreboard queue matches every commit strobe against the transaction that was expected, so any extra or missing codec access is reported.

// File: rtl/acp_pkg.sv
package acp_pkg;

    localparam int DATA_W   = 16;
    localparam int IDX_W    = 7;
    localparam int CODECS   = 2;
    localparam int ENTRIES  = 1 << (IDX_W - 1);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [7:0]        index;
        logic              sel_hi;
        logic              sel_cdc;
        logic [CODECS-1:0] vflag;
        logic              busy;
        logic              cmd_sel;
        logic              cmd_wr;
        logic [IDX_W-1:0]  cmd_idx;
    } port_state_t;

    function automatic logic [7:0] status_byte(input port_state_t s);
        return {s.sel_hi, s.sel_cdc, 2'b00, s.vflag[1], 1'b0, s.vflag[0], s.busy};
    endfunction

endpackage

// File: rtl/acp_lat_timer.sv
module acp_lat_timer #(
    parameter int LATENCY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expire
);
    localparam int CW = $clog2(LATENCY + 1);
    localparam logic [CW-1:0] LOAD = CW'(LATENCY);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start)
            cnt_d = LOAD;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expire = (cnt_q == CW'(1));

    // R9
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LOAD);

    // R9
    start_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> (cnt_q == '0));

endmodule

// File: rtl/acp_shadow_store.sv
module acp_shadow_store #(
    parameter int NUM_CODECS = 2,
    parameter int ENTRIES    = 64,
    parameter int DW         = 16
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [$clog2(NUM_CODECS)-1:0] wr_sel,
    input  logic [$clog2(ENTRIES)-1:0]    wr_entry,
    input  logic [DW-1:0]                 wr_data,
    input  logic [$clog2(NUM_CODECS)-1:0] rd_sel,
    input  logic [$clog2(ENTRIES)-1:0]    rd_entry,
    output logic [DW-1:0]                 rd_data
);
    logic [DW-1:0] bank_rd [NUM_CODECS];

    for (genvar c = 0; c < NUM_CODECS; c++) begin : g_bank
        logic [DW-1:0] mem_q [ENTRIES];
        logic          hit;

        assign hit = wr_en && (int'(wr_sel) == c);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int i = 0; i < ENTRIES; i++) mem_q[i] <= '0;
            end else if (hit) begin
                mem_q[wr_entry] <= wr_data;
            end
        end

        assign bank_rd[c] = mem_q[rd_entry];
    end

    assign rd_data = bank_rd[rd_sel];

endmodule

// File: rtl/codec_reg_port.sv
module codec_reg_port
    import acp_pkg::*;
#(
    parameter int LATENCY = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                host_we,
    input  logic [3:0]          host_be,
    input  logic [31:0]         host_wdata,
    output logic [31:0]         host_rdata,
    input  logic [CODECS-1:0]   cdc_present,
    output logic                cdc_req,
    output logic                cdc_commit,
    output logic                cdc_write,
    output logic                cdc_sel,
    output logic [IDX_W-1:0]    cdc_index,
    output logic [DATA_W-1:0]   cdc_wdata,
    input  logic [DATA_W-1:0]   cdc_rdata,
    input  logic                shd_sel,
    input  logic [IDX_W-1:0]    shd_index,
    output logic [DATA_W-1:0]   shd_data
);
    localparam int EW = IDX_W - 1;

    port_state_t st_d, st_q;
    logic        start;
    logic        expire;
    logic        accept;
    logic        eff_sel;
    logic [7:0]  new_idx;

    always_comb begin
        st_d    = st_q;
        start   = 1'b0;
        accept  = host_we && !st_q.busy;
        new_idx = host_wdata[23:16];
        eff_sel = host_be[3] ? host_wdata[30] : st_q.sel_cdc;

        // completion of an in-flight transaction
        if (st_q.busy && expire) begin
            st_d.busy = 1'b0;
            if (!st_q.cmd_wr) begin
                st_d.data                = cdc_rdata;
                st_d.vflag[st_q.cmd_sel] = 1'b1;
            end
        end

        // status byte: top two bits from host, low bits held
        if (host_we && host_be[3]) begin
            st_d.sel_hi  = host_wdata[31];
            st_d.sel_cdc = host_wdata[30];
        end

        if (accept) begin
            if (host_be[0]) st_d.data[7:0]  = host_wdata[7:0];
            if (host_be[1]) st_d.data[15:8] = host_wdata[15:8];
            if (host_be[2]) begin
                st_d.index = new_idx;
                if (cdc_present[eff_sel]) begin
                    if (new_idx[0]) begin
                        if (new_idx[7]) begin
                            st_d.data           = '0;
                            st_d.vflag[eff_sel] = 1'b1;
                        end
                    end else begin
                        start        = 1'b1;
                        st_d.busy    = 1'b1;
                        st_d.cmd_sel = eff_sel;
                        st_d.cmd_wr  = !new_idx[7];
                        st_d.cmd_idx = new_idx[6:0];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    acp_lat_timer #(.LATENCY(LATENCY)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start),
        .expire (expire)
    );

    acp_shadow_store #(
        .NUM_CODECS (CODECS),
        .ENTRIES    (ENTRIES),
        .DW         (DATA_W)
    ) u_shadow (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cdc_commit),
        .wr_sel   (st_q.cmd_sel),
        .wr_entry (st_q.cmd_idx[IDX_W-1:1]),
        .wr_data  (st_q.cmd_wr ? st_q.data : cdc_rdata),
        .rd_sel   (shd_sel),
        .rd_entry (shd_index[IDX_W-1:1]),
        .rd_data  (shd_data)
    );

    assign host_rdata = {status_byte(st_q), st_q.index, st_q.data};
    assign cdc_req    = st_q.busy;
    assign cdc_commit = st_q.busy && expire;
    assign cdc_write  = st_q.cmd_wr;
    assign cdc_sel    = st_q.cmd_sel;
    assign cdc_index  = st_q.cmd_idx;
    assign cdc_wdata  = st_q.data;

    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req && !cdc_commit) |=> ($stable(host_rdata[23:0])));

    // R9
    req_until_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_req && !cdc_commit) |=> cdc_req);

    // R9
    req_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cdc_req) |-> $past(cdc_commit));

    // R3
    rd_flag0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_commit && !cdc_write && !cdc_sel) |=> host_rdata[25]);

    // R3
    rd_flag1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cdc_commit && !cdc_write && cdc_sel) |=> host_rdata[27]);

    // R4
    odd_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && host_be[2] && host_wdata[16] && !cdc_req) |=> !cdc_req);

    // R11
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(host_rdata[25]) == 1'b0);

endmodule

// File: tb/codec_reg_port_bench.sv
module codec_reg_port_bench;
    localparam int LAT = 4;

    typedef struct packed {
        logic        sel;
        logic        wr;
        logic [6:0]  idx;
        logic [15:0] wd;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_we = 1'b0;
    logic [3:0]  host_be = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic [1:0]  cdc_present = 2'b11;
    logic        cdc_req, cdc_commit, cdc_write, cdc_sel;
    logic [6:0]  cdc_index;
    logic [15:0] cdc_wdata, cdc_rdata;
    logic        shd_sel = 1'b0;
    logic [6:0]  shd_index = '0;
    logic [15:0] shd_data;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];
    logic [15:0] mdl [2][64];

    // expected register state
    logic [15:0] e_data = '0;
    logic [7:0]  e_idx = '0;
    logic        e_s7 = 1'b0, e_s6 = 1'b0, e_f0 = 1'b0, e_f1 = 1'b0;

    always #2 clk = ~clk;

    codec_reg_port #(.LATENCY(LAT)) u_codec_reg_port (
        .clk(clk), .rst_n(rst_n), .host_we(host_we), .host_be(host_be),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .cdc_present(cdc_present), .cdc_req(cdc_req), .cdc_commit(cdc_commit),
        .cdc_write(cdc_write), .cdc_sel(cdc_sel), .cdc_index(cdc_index),
        .cdc_wdata(cdc_wdata), .cdc_rdata(cdc_rdata),
        .shd_sel(shd_sel), .shd_index(shd_index), .shd_data(shd_data)
    );

    function automatic logic [15:0] init_val(input int c, input int i);
        return 16'(16'h1000 * (c + 1) + i * 16'h0101);
    endfunction

    // codec register model
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int c = 0; c < 2; c++)
                for (int i = 0; i < 64; i++) mdl[c][i] <= init_val(c, i);
        end else if (cdc_commit && cdc_write) begin
            mdl[cdc_sel][cdc_index[6:1]] <= cdc_wdata;
        end
    end
    assign cdc_rdata = mdl[cdc_sel][cdc_index[6:1]];

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input logic busy);
        return {e_s7, e_s6, 2'b00, e_f1, 1'b0, e_f0, busy, e_idx, e_data};
    endfunction

    // monitor: every commit must match the next expected transaction
    always @(negedge clk) begin
        if (rst_n && cdc_commit) begin
            if (sb_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R5/R7 unexpected codec access act=%h exp=none",
                         {cdc_sel, cdc_write, cdc_index, cdc_wdata});
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk("R2 commit transaction", {7'd0, cdc_sel, cdc_write, cdc_index, cdc_wdata},
                    {7'd0, e.sel, e.wr, e.idx, e.wd});
            end
        end
    end

    task automatic hwrite(input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_be = be; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0; host_be = '0;
    endtask

    task automatic shadow_chk(input string req, input logic s, input logic [6:0] idx,
                              input logic [15:0] exp);
        shd_sel = s; shd_index = idx;
        #1;
        chk(req, {16'd0, shd_data}, {16'd0, exp});
    endtask

    // called right after hwrite returns (one edge since the start)
    task automatic wait_done(input logic [15:0] new_data, input logic rd, input logic s);
        chk("R9 busy after start", host_rdata, exp_word(1'b1));
        repeat (LAT - 1) @(negedge clk);
        chk("R9 busy until last cycle", host_rdata, exp_word(1'b1));
        @(negedge clk);
        if (rd) begin
            e_data = new_data;
            if (s) e_f1 = 1'b1; else e_f0 = 1'b1;
        end
        chk("R9 done after LATENCY", host_rdata, exp_word(1'b0));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1
        chk("R1 reset word", host_rdata, 32'h0);
        chk("R1 no request", {31'd0, cdc_req}, 32'd0);
        shadow_chk("R1 shadow zero", 1'b1, 7'h10, 16'h0000);

        // R2/R10 aligned write to codec 0, data and index in one write
        sb_q.push_back('{sel: 1'b0, wr: 1'b1, idx: 7'h02, wd: 16'h1234});
        hwrite(4'b1111, {8'h00, 8'h02, 16'h1234});
        e_idx = 8'h02; e_data = 16'h1234;
        wait_done(16'h0, 1'b0, 1'b0);
        shadow_chk("R2 shadow after write", 1'b0, 7'h02, 16'h1234);
        chk("R2 codec model written", {16'd0, mdl[0][1]}, {16'd0, 16'h1234});

        // R7 absent secondary codec
        cdc_present = 2'b01;
        hwrite(4'b1100, {8'h40, 8'h90, 16'h0000});
        e_idx = 8'h90; e_s6 = 1'b1;
        chk("R7 absent no busy", host_rdata, exp_word(1'b0));
        repeat (LAT + 1) @(negedge clk);
        chk("R7 absent data kept", host_rdata, exp_word(1'b0));
        cdc_present = 2'b11;

        // R3 read from secondary codec
        sb_q.push_back('{sel: 1'b1, wr: 1'b0, idx: 7'h10, wd: 16'h1234});
        hwrite(4'b1100, {8'h40, 8'h90, 16'h0000});
        wait_done(init_val(1, 8), 1'b1, 1'b1);
        shadow_chk("R3 shadow after read", 1'b1, 7'h10, init_val(1, 8));

        // R4 odd read on primary codec
        hwrite(4'b1100, {8'h00, 8'h85, 16'h0000});
        e_idx = 8'h85; e_s6 = 1'b0; e_data = 16'h0000; e_f0 = 1'b1;
        chk("R4 odd read zero and flag", host_rdata, exp_word(1'b0));
        repeat (LAT) @(negedge clk);
        chk("R4 odd read stays idle", host_rdata, exp_word(1'b0));

        // R3 aligned read back of codec 0 index 2
        sb_q.push_back('{sel: 1'b0, wr: 1'b0, idx: 7'h02, wd: 16'h0000});
        hwrite(4'b0100, {8'h00, 8'h82, 16'h0000});
        e_idx = 8'h82;
        wait_done(16'h1234, 1'b1, 1'b0);

        // R5 odd write does nothing beyond storing the lanes
        hwrite(4'b0111, {8'h00, 8'h07, 16'hBEEF});
        e_idx = 8'h07; e_data = 16'hBEEF;
        chk("R5 odd write no busy", host_rdata, exp_word(1'b0));
        repeat (LAT) @(negedge clk);
        shadow_chk("R5 shadow unchanged", 1'b0, 7'h06, 16'h0000);
        chk("R5 codec unchanged", {16'd0, mdl[0][3]}, {16'd0, init_val(0, 3)});

        // R6/R11 status byte write keeps low bits incl. flags
        hwrite(4'b1000, 32'hFF00_0000);
        e_s7 = 1'b1; e_s6 = 1'b1;
        chk("R6 R11 status write", host_rdata, exp_word(1'b0));

        // R8 writes while busy are ignored
        sb_q.push_back('{sel: 1'b0, wr: 1'b1, idx: 7'h20, wd: 16'hC0DE});
        hwrite(4'b1111, {8'h00, 8'h20, 16'hC0DE});
        e_s7 = 1'b0; e_s6 = 1'b0; e_idx = 8'h20; e_data = 16'hC0DE;
        hwrite(4'b0111, {8'h00, 8'h84, 16'hFFFF});
        chk("R8 lanes held while busy", host_rdata, exp_word(1'b1));
        repeat (LAT - 2) @(negedge clk);
        chk("R8 done with original lanes", host_rdata, exp_word(1'b0));
        shadow_chk("R8 shadow from first write", 1'b0, 7'h20, 16'hC0DE);

        // R10 data, select and index in one write to the secondary codec
        sb_q.push_back('{sel: 1'b1, wr: 1'b1, idx: 7'h3E, wd: 16'h7777});
        hwrite(4'b1111, {8'h40, 8'h3E, 16'h7777});
        e_s6 = 1'b1; e_idx = 8'h3E; e_data = 16'h7777;
        wait_done(16'h0, 1'b0, 1'b1);
        shadow_chk("R10 combined write shadow", 1'b1, 7'h3E, 16'h7777);
        chk("R10 combined write codec", {16'd0, mdl[1][31]}, {16'd0, 16'h7777});

        repeat (2) @(negedge clk);
        chk("R2 scoreboard drained", sb_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule